// File: doc/BRIEF.md
# Shared GPIO Port Controller

This block drives seven pads from a small register file: a five-pin port A and a two-pin port B. Software sets each pin's direction, output level and pull-up through an 8-bit register bus with single-cycle write strobes. Reads are combinational. Reading the data register returns the latched output level for output pins. For input pins it returns the pad level after synchronization.

Port A pins are shared with on-chip peripherals. A per-pin peripheral enable hands that pin's output value and output enable to the peripheral, and the GPIO registers keep their contents. Port B is GPIO only. A receiver-enable input takes both port B pins into high impedance and removes their pull-ups. The register values are left unchanged while this is in effect.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset every data, direction and pull-up register is 0, so every pad has its output enable low and its pull-up off.
- R2: A direction bit of 1 makes the pin an output: its output enable is 1 and its output level equals the data register bit. A direction bit of 0 makes it an input with output enable 0.
- R3: A read of a data register returns the register bit for pins whose direction bit is 1, and the synchronized pad level for pins whose direction bit is 0.
- R4: A pad level change becomes readable after exactly two rising clock edges. After only one edge the previous level is still read.
- R5: While port A peripheral enable bit i is 1, pin i takes its output level and output enable from the peripheral inputs, whatever the GPIO registers hold. The GPIO registers keep their values.
- R6: While the receiver enable is 1, both port B output enables and pull-ups are 0. The port B registers keep their values.
- R7: A pin's pull-up is on only when its pull-up bit is 1, its direction bit is 0, it is not taken over by a peripheral and its port is not forced to high impedance.
- R8: Writes keep only the low bits that fit the port, 5 for port A and 2 for port B. The other read bits are 0.
- R9: The register offsets are 0, 1 and 2 for port A data, direction and pull-up, and 4, 5 and 6 for port B data, direction and pull-up. Offsets 3 and 7 read 0 and ignore writes.
- R10: A register changes only on a bus write strobe addressed to its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pa_in | input | 5 | Port A pad levels |
| pa_out | output | 5 | Port A output levels |
| pa_oe | output | 5 | Port A output enables |
| pa_pu | output | 5 | Port A pull-up enables |
| pa_alt_en | input | 5 | Per-pin peripheral takeover for port A |
| pa_alt_out | input | 5 | Peripheral output levels |
| pa_alt_oe | input | 5 | Peripheral output enables |
| pb_in | input | 2 | Port B pad levels |
| pb_out | output | 2 | Port B output levels |
| pb_oe | output | 2 | Port B output enables |
| pb_pu | output | 2 | Port B pull-up enables |
| lfrx_en | input | 1 | Receiver enable; forces port B to high impedance |

## Verification
A table of register writes with read-back covers patterns that carry set bits above each port's width. This separates correct masking from pass-through and catches wrong offset decoding, including the unmapped offsets. Mixed direction masks show whether a data read picks the register bit or the pad bit per pin. A pad change sampled after one and after two edges pins the synchronizer depth to exactly two. Partial peripheral-enable masks, with peripheral values that differ from the GPIO ones, separate a per-pin takeover from a whole-port takeover. Toggling the receiver enable with port B set to drive and pull up shows both the forced state and that the register settings come back unchanged.

// File: rtl/gpio_shared_pkg.sv
// Package: shared widths and register offsets for the shared GPIO port.
// Assumes an 8-bit bus with a 3-bit offset; the offsets are the decode contract.
package gpio_shared_pkg;
    localparam int PA_WIDTH  = 5;
    localparam int PB_WIDTH  = 2;
    localparam int BUS_WIDTH = 8;
    localparam int OFS_WIDTH = 3;

    localparam logic [OFS_WIDTH-1:0] OFS_A_DAT = 3'd0;
    localparam logic [OFS_WIDTH-1:0] OFS_A_DIR = 3'd1;
    localparam logic [OFS_WIDTH-1:0] OFS_A_PUL = 3'd2;
    localparam logic [OFS_WIDTH-1:0] OFS_B_DAT = 3'd4;
    localparam logic [OFS_WIDTH-1:0] OFS_B_DIR = 3'd5;
    localparam logic [OFS_WIDTH-1:0] OFS_B_PUL = 3'd6;
endpackage

// File: rtl/gpio_sync.sv
// Two-stage input synchronizer, one stage pair per pin.
// Assumes the pad levels are asynchronous to clk; reset clears both stages.
module gpio_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bank.sv
// One GPIO port of W pins: data, direction and pull-up registers, input
// synchronizer and the per-pin pad control with peripheral takeover and a
// whole-port high-impedance force. Assumes write strobes are one-hot.
module gpio_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dat,
    input  logic         wr_dir,
    input  logic         wr_pul,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] ovr_en,
    input  logic [W-1:0] ovr_out,
    input  logic [W-1:0] ovr_oe,
    input  logic         hiz,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] rd_dat,
    output logic [W-1:0] rd_dir,
    output logic [W-1:0] rd_pul
);
    logic [W-1:0] dat_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pul_q;
    logic [W-1:0] pin_sync;

    // Register file: each register loads only on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
            pul_q <= '0;
        end else begin
            if (wr_dat) dat_q <= wdata;
            if (wr_dir) dir_q <= wdata;
            if (wr_pul) pul_q <= wdata;
        end
    end

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // Per-pin pad control.
    for (genvar i = 0; i < W; i++) begin : g_pin
        // Select the pin's driver: peripheral, forced off or GPIO.
        always_comb begin
            if (ovr_en[i]) begin
                pad_out[i] = ovr_out[i];
                pad_oe[i]  = ovr_oe[i];
                pad_pu[i]  = 1'b0;
            end else if (hiz) begin
                pad_out[i] = dat_q[i];
                pad_oe[i]  = 1'b0;
                pad_pu[i]  = 1'b0;
            end else begin
                pad_out[i] = dat_q[i];
                pad_oe[i]  = dir_q[i];
                pad_pu[i]  = pul_q[i] & ~dir_q[i];
            end
        end

        // Data read-back: latched value for outputs, pad level for inputs.
        always_comb begin
            rd_dat[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
        end
    end

    assign rd_dir = dir_q;
    assign rd_pul = pul_q;

    logic [1:0] rst_age;

    // Count edges since reset, saturating at 3, for the history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)              rst_age <= 2'd0;
        else if (rst_age != 2'd3) rst_age <= rst_age + 2'd1;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dat_q == '0 && dir_q == '0 && pul_q == '0));

    // R4
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_age == 2'd3) |-> (pin_sync == $past(pad_in, 2)));

    // R6
    hiz_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz && ovr_en == '0) |-> (pad_oe == '0 && pad_pu == '0));

    // R7
    pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

    // R10
    pul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pul |=> $stable(pul_q));

    // R10
    dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dat |=> $stable(dat_q));
endmodule

// File: rtl/gpio_shared_port.sv
// Top: offset decode, two GPIO banks and the read mux. Port A accepts
// per-pin peripheral takeover; port B is forced to high impedance by lfrx_en.
// Assumes reads are combinational and writes land on the strobe's clock edge.
module gpio_shared_port
    import gpio_shared_pkg::*;
#(
    parameter int PA_W  = PA_WIDTH,
    parameter int PB_W  = PB_WIDTH,
    parameter int BUS_W = BUS_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [OFS_WIDTH-1:0] bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PA_W-1:0]      pa_in,
    output logic [PA_W-1:0]      pa_out,
    output logic [PA_W-1:0]      pa_oe,
    output logic [PA_W-1:0]      pa_pu,
    input  logic [PA_W-1:0]      pa_alt_en,
    input  logic [PA_W-1:0]      pa_alt_out,
    input  logic [PA_W-1:0]      pa_alt_oe,
    input  logic [PB_W-1:0]      pb_in,
    output logic [PB_W-1:0]      pb_out,
    output logic [PB_W-1:0]      pb_oe,
    output logic [PB_W-1:0]      pb_pu,
    input  logic                 lfrx_en
);
    localparam int PA_PAD = BUS_W - PA_W;
    localparam int PB_PAD = BUS_W - PB_W;

    logic [PA_W-1:0] a_dat, a_dir, a_pul;
    logic [PB_W-1:0] b_dat, b_dir, b_pul;
    logic            wa_dat, wa_dir, wa_pul, wb_dat, wb_dir, wb_pul;

    // Decode the write strobe to one register.
    always_comb begin
        wa_dat = bus_wr && (bus_addr == OFS_A_DAT);
        wa_dir = bus_wr && (bus_addr == OFS_A_DIR);
        wa_pul = bus_wr && (bus_addr == OFS_A_PUL);
        wb_dat = bus_wr && (bus_addr == OFS_B_DAT);
        wb_dir = bus_wr && (bus_addr == OFS_B_DIR);
        wb_pul = bus_wr && (bus_addr == OFS_B_PUL);
    end

    gpio_bank #(.W(PA_W)) u_port_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dat  (wa_dat),
        .wr_dir  (wa_dir),
        .wr_pul  (wa_pul),
        .wdata   (bus_wdata[PA_W-1:0]),
        .ovr_en  (pa_alt_en),
        .ovr_out (pa_alt_out),
        .ovr_oe  (pa_alt_oe),
        .hiz     (1'b0),
        .pad_in  (pa_in),
        .pad_out (pa_out),
        .pad_oe  (pa_oe),
        .pad_pu  (pa_pu),
        .rd_dat  (a_dat),
        .rd_dir  (a_dir),
        .rd_pul  (a_pul)
    );

    gpio_bank #(.W(PB_W)) u_port_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dat  (wb_dat),
        .wr_dir  (wb_dir),
        .wr_pul  (wb_pul),
        .wdata   (bus_wdata[PB_W-1:0]),
        .ovr_en  ({PB_W{1'b0}}),
        .ovr_out ({PB_W{1'b0}}),
        .ovr_oe  ({PB_W{1'b0}}),
        .hiz     (lfrx_en),
        .pad_in  (pb_in),
        .pad_out (pb_out),
        .pad_oe  (pb_oe),
        .pad_pu  (pb_pu),
        .rd_dat  (b_dat),
        .rd_dir  (b_dir),
        .rd_pul  (b_pul)
    );

    // Read mux, zero-extended; unmapped offsets read 0.
    always_comb begin
        case (bus_addr)
            OFS_A_DAT: bus_rdata = {{PA_PAD{1'b0}}, a_dat};
            OFS_A_DIR: bus_rdata = {{PA_PAD{1'b0}}, a_dir};
            OFS_A_PUL: bus_rdata = {{PA_PAD{1'b0}}, a_pul};
            OFS_B_DAT: bus_rdata = {{PB_PAD{1'b0}}, b_dat};
            OFS_B_DIR: bus_rdata = {{PB_PAD{1'b0}}, b_dir};
            OFS_B_PUL: bus_rdata = {{PB_PAD{1'b0}}, b_pul};
            default:   bus_rdata = '0;
        endcase
    end

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PA_W] == '0);

    // R6
    lfrx_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfrx_en |-> (pb_oe == '0 && pb_pu == '0));

    // R5
    alt_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_pu & pa_alt_en) == '0);
endmodule

// File: tb/gpio_shared_port_tb.sv
`timescale 1ns/1ps
module gpio_shared_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] pa_in = '0, pa_out, pa_oe, pa_pu;
    logic [4:0] pa_alt_en = '0, pa_alt_out = '0, pa_alt_oe = '0;
    logic [1:0] pb_in = '0, pb_out, pb_oe, pb_pu;
    logic       lfrx_en = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_shared_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_pu(pa_pu),
        .pa_alt_en(pa_alt_en), .pa_alt_out(pa_alt_out), .pa_alt_oe(pa_alt_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_pu(pb_pu),
        .lfrx_en(lfrx_en)
    );

    // Vector: [18:16] offset, [15:8] write data, [7:0] expected read-back.
    localparam logic [18:0] VEC [10] = '{
        {3'd1, 8'hFF, 8'h1F},   // R8 A dir, upper bits dropped
        {3'd2, 8'hAA, 8'h0A},   // R8 A pull
        {3'd5, 8'h03, 8'h03},   // R9 B dir
        {3'd6, 8'h5D, 8'h01},   // R8 B pull
        {3'd0, 8'hF5, 8'h15},   // R3 A data, all outputs
        {3'd4, 8'h0E, 8'h02},   // R3 B data, all outputs
        {3'd3, 8'hFF, 8'h00},   // R9 unmapped
        {3'd7, 8'hFF, 8'h00},   // R9 unmapped
        {3'd1, 8'h00, 8'h00},   // R9 A dir to inputs
        {3'd5, 8'h02, 8'h02}    // R9 B dir mixed
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            bus_read(a[2:0], rd);
            check("R1 reg", rd, 8'h00);
        end
        check("R1 pa_oe", {3'b0, pa_oe}, 8'h00);
        check("R1 pa_pu", {3'b0, pa_pu}, 8'h00);
        check("R1 pb_oe", {6'b0, pb_oe}, 8'h00);
        check("R1 pb_pu", {6'b0, pb_pu}, 8'h00);

        // R8 R9 R10 vector table
        for (int i = 0; i < 10; i++) begin
            bus_write(VEC[i][18:16], VEC[i][15:8]);
            bus_read(VEC[i][18:16], rd);
            check("R8/R9 vec", rd, VEC[i][7:0]);
        end
        // R10: earlier registers untouched by later writes
        bus_read(3'd2, rd); check("R10 A pull", rd, 8'h0A);
        bus_read(3'd6, rd); check("R10 B pull", rd, 8'h01);

        // R2 and R7 after the table: A all inputs, B pin1 output
        #0.5;
        check("R2 pa_oe", {3'b0, pa_oe}, 8'h00);
        check("R7 pa_pu", {3'b0, pa_pu}, 8'h0A);
        check("R2 pb_oe", {6'b0, pb_oe}, 8'h02);
        check("R2 pb_out1", {7'b0, pb_out[1]}, 8'h01);
        check("R7 pb_pu", {6'b0, pb_pu}, 8'h01);

        // R4 synchronizer depth
        @(negedge clk);
        pa_in = 5'b10011;
        @(posedge clk); #0.5;
        bus_read(3'd0, rd); check("R4 one edge", rd, 8'h00);
        @(posedge clk); #0.5;
        bus_read(3'd0, rd); check("R4 two edges", rd, 8'h13);

        // R3 mixed direction on B: bit1 register, bit0 pad
        @(negedge clk);
        pb_in = 2'b01;
        repeat (3) @(negedge clk);
        bus_read(3'd4, rd); check("R3 B mixed", rd, 8'h03);
        pb_in = 2'b00;
        repeat (3) @(negedge clk);
        bus_read(3'd4, rd); check("R3 B mixed low", rd, 8'h02);

        // R5 per-pin takeover on port A
        bus_write(3'd1, 8'h1F);
        check("R2 pa_out", {3'b0, pa_out}, 8'h15);
        check("R2 pa_oe all", {3'b0, pa_oe}, 8'h1F);
        pa_alt_en = 5'b00101; pa_alt_out = 5'b00000; pa_alt_oe = 5'b00001;
        #0.5;
        check("R5 pa_out", {3'b0, pa_out}, 8'h10);
        check("R5 pa_oe", {3'b0, pa_oe}, 8'h1B);
        bus_read(3'd1, rd); check("R5 dir kept", rd, 8'h1F);

        // R7 pull-up masked by takeover on inputs
        bus_write(3'd1, 8'h00);
        pa_alt_en = 5'b00010; pa_alt_oe = 5'b00000;
        #0.5;
        check("R7 pa_pu alt", {3'b0, pa_pu}, 8'h08);
        pa_alt_en = '0;
        #0.5;
        check("R7 pa_pu free", {3'b0, pa_pu}, 8'h0A);

        // R6 receiver enable forces port B off
        bus_write(3'd5, 8'h02);
        bus_write(3'd6, 8'h03);
        lfrx_en = 1'b1;
        #0.5;
        check("R6 pb_oe", {6'b0, pb_oe}, 8'h00);
        check("R6 pb_pu", {6'b0, pb_pu}, 8'h00);
        bus_read(3'd5, rd); check("R6 dir kept", rd, 8'h02);
        bus_read(3'd6, rd); check("R6 pull kept", rd, 8'h03);
        lfrx_en = 1'b0;
        #0.5;
        check("R6 pb_oe back", {6'b0, pb_oe}, 8'h02);
        check("R6 pb_pu back", {6'b0, pb_pu}, 8'h01);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        bus_read(3'd2, rd); check("R1 re-reset A pull", rd, 8'h00);
        bus_read(3'd5, rd); check("R1 re-reset B dir", rd, 8'h00);
        check("R1 re-reset pb_oe", {6'b0, pb_oe}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule